// File: doc/BRIEF.md
# Dual-Rail Early-Output AND Stage

This block is one pipeline stage of a delay-insensitive dual-rail datapath. It takes two operand words, each split into lanes. Every lane carries one logical bit on a pair of rails. The stage computes the lane-wise AND and passes the result to the next stage under a four-phase, return-to-zero handshake. A lane's result goes out as soon as it is decided. A zero on either operand decides the lane on its own. A one needs both operands to be one.

Completion is not based on any delay estimate. The stage detects it from the codes on the wires. The acknowledge sent upstream is held back until every lane of both operands has actually arrived, even when every output lane was decided early. It is then held high until both operands have returned to NULL. A slow operand therefore finishes its data and null phases inside the current token and cannot be taken for the next one.

The state-holding elements are modelled as rendezvous (C-element) registers clocked by `clk` and cleared by the active-low `rst_n`. A parameter selects between the early-output lane function and a conventional lane that waits for both operands.

Top module: `dr_eo_stage`

## Requirements
- R1: Each lane i occupies bits [2i+1:2i] of a dual-rail bus. Bit 2i is the false rail and bit 2i+1 is the true rail. The code 2'b00 is NULL, 2'b01 is logic zero and 2'b10 is logic one.
- R2: No output lane ever carries the code 2'b11.
- R3: With EARLY_OUTPUT=1, a NULL output lane becomes zero at the next clock edge when `out_ack` is low and either operand of that lane is zero, even while the other operand is still NULL.
- R4: An output lane becomes one only at the edge after both of its operands are one. A single operand at one leaves the lane NULL.
- R5: A valid output lane keeps its value until `out_ack` is high and both operands of that lane are NULL. The lane then returns to NULL at the next edge.
- R6: While `out_ack` is high, a NULL output lane stays NULL whatever the operands carry.
- R7: `in_ack` rises at the edge after `out_ack` is high and every lane of both operands is valid. It stays low while any operand lane is still NULL, even when all output lanes are already decided.
- R8: `in_ack` falls at the edge after `out_ack` is low and every lane of both operands is NULL.
- R9: `out_done` rises at the edge after all output lanes are valid. It falls at the edge after all output lanes are NULL.
- R10: While `rst_n` is low, all output rails are NULL and `in_ack` and `out_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state-holding elements |
| rst_n | input | 1 | Active-low reset; clears all rails and acknowledges |
| a_dr | input | 2*LANES | First operand, dual-rail per lane |
| b_dr | input | 2*LANES | Second operand, dual-rail per lane |
| in_ack | output | 1 | Acknowledge to the upstream stage |
| out_dr | output | 2*LANES | Result, dual-rail per lane |
| out_ack | input | 1 | Acknowledge from the downstream stage |
| out_done | output | 1 | Output completion: high when the whole result word is valid |

## Verification
The bench builds the stage with LANES=4 and EARLY_OUTPUT=1. With four lanes, a single token can mix lanes that an early zero has decided with lanes that must wait for the late operand. Random arrival skews of zero to five cycles between the operands mean that some tokens offer a visible early-zero window, in which the late operand is absent and `in_ack` must stay low. A scoreboard matches each result word against the AND of the operands, across back-to-back tokens.

// File: rtl/dr_pkg.sv
package dr_pkg;

   typedef logic [1:0] dr_t;

   // rail order: bit 0 is the false rail, bit 1 the true rail
   localparam dr_t DR_NULL = 2'b00;
   localparam dr_t DR_ZERO = 2'b01;
   localparam dr_t DR_ONE  = 2'b10;
   localparam dr_t DR_BAD  = 2'b11;

   function automatic logic dr_is_valid(input dr_t x);
      return (x == DR_ZERO) || (x == DR_ONE);
   endfunction

endpackage

// File: rtl/dr_celem.sv
module dr_celem #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hi_i,
   input  logic [N-1:0] lo_i,
   output logic         q_o
);

   if (N < 1) begin : g_bad_n
      $error("dr_celem: N must be at least 1");
   end

   logic all_hi;
   logic all_lo;

   assign all_hi = &hi_i;
   assign all_lo = &lo_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= 1'b0;
      end else if (all_hi) begin
         q_o <= 1'b1;
      end else if (all_lo) begin
         q_o <= 1'b0;
      end
   end

   AST_CELEM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&hi_i) && !(&lo_i)) |=> (q_o == $past(q_o))); // R9

endmodule

// File: rtl/dr_detect.sv
module dr_detect #(
   parameter int LANES = 4,
   localparam int W = 2 * LANES
) (
   input  logic [W-1:0] bus_i,
   output logic         all_valid_o,
   output logic         all_null_o
);

   logic [LANES-1:0] lane_valid;
   logic [LANES-1:0] lane_null;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_valid[i] = bus_i[2*i] ^ bus_i[2*i+1];
      assign lane_null[i]  = ~(bus_i[2*i] | bus_i[2*i+1]);
   end

   assign all_valid_o = &lane_valid;
   assign all_null_o  = &lane_null;

endmodule

// File: rtl/dr_eo_and.sv
module dr_eo_and
   import dr_pkg::*;
#(
   parameter bit EARLY_OUTPUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  dr_t  a_i,
   input  dr_t  b_i,
   input  logic out_ack_i,
   output dr_t  q_o
);

   logic decide_zero;
   logic decide_one;
   logic inputs_null;

   assign decide_one  = (a_i == DR_ONE) && (b_i == DR_ONE);
   assign inputs_null = (a_i == DR_NULL) && (b_i == DR_NULL);

   if (EARLY_OUTPUT) begin : g_early
      // one zero operand settles the lane by itself
      assign decide_zero = (a_i == DR_ZERO) || (b_i == DR_ZERO);
   end else begin : g_full
      // wait for both operands before deciding
      assign decide_zero = dr_is_valid(a_i) && dr_is_valid(b_i) && !decide_one;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= DR_NULL;
      end else if (q_o == DR_NULL) begin
         if (!out_ack_i) begin
            if (decide_zero) begin
               q_o <= DR_ZERO;
            end else if (decide_one) begin
               q_o <= DR_ONE;
            end
         end
      end else if (out_ack_i && inputs_null) begin
         q_o <= DR_NULL;
      end
   end

   AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      q_o != DR_BAD); // R2

   AST_EARLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (EARLY_OUTPUT && q_o == DR_NULL && !out_ack_i &&
       (a_i == DR_ZERO || b_i == DR_ZERO)) |=> (q_o == DR_ZERO)); // R3

   AST_ONE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_o == DR_ONE) |-> $past(a_i == DR_ONE && b_i == DR_ONE)); // R4

   AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o != DR_NULL && !(out_ack_i && a_i == DR_NULL && b_i == DR_NULL))
      |=> (q_o == $past(q_o))); // R5

   AST_NO_DATA_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o == DR_NULL && out_ack_i) |=> (q_o == DR_NULL)); // R6

endmodule

// File: rtl/dr_eo_stage.sv
module dr_eo_stage
   import dr_pkg::*;
#(
   parameter int LANES        = 4,
   parameter bit EARLY_OUTPUT = 1'b1,
   localparam int W = 2 * LANES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_dr,
   input  logic [W-1:0] b_dr,
   output logic         in_ack,
   output logic [W-1:0] out_dr,
   input  logic         out_ack,
   output logic         out_done
);

   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("dr_eo_stage: LANES must lie in 1..64");
   end

   logic a_all_valid, a_all_null;
   logic b_all_valid, b_all_null;
   logic q_all_valid, q_all_null;

   dr_detect #(.LANES(LANES)) u_det_a (
      .bus_i(a_dr), .all_valid_o(a_all_valid), .all_null_o(a_all_null));
   dr_detect #(.LANES(LANES)) u_det_b (
      .bus_i(b_dr), .all_valid_o(b_all_valid), .all_null_o(b_all_null));
   dr_detect #(.LANES(LANES)) u_det_q (
      .bus_i(out_dr), .all_valid_o(q_all_valid), .all_null_o(q_all_null));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      dr_eo_and #(.EARLY_OUTPUT(EARLY_OUTPUT)) u_and (
         .clk      (clk),
         .rst_n    (rst_n),
         .a_i      (a_dr[2*i +: 2]),
         .b_i      (b_dr[2*i +: 2]),
         .out_ack_i(out_ack),
         .q_o      (out_dr[2*i +: 2])
      );
   end

   // upstream acknowledge: a rendezvous of downstream ack and both operands
   dr_celem #(.N(3)) u_ack (
      .clk  (clk),
      .rst_n(rst_n),
      .hi_i ({out_ack, a_all_valid, b_all_valid}),
      .lo_i ({~out_ack, a_all_null, b_all_null}),
      .q_o  (in_ack)
   );

   // output completion
   dr_celem #(.N(1)) u_done (
      .clk  (clk),
      .rst_n(rst_n),
      .hi_i (q_all_valid),
      .lo_i (q_all_null),
      .q_o  (out_done)
   );

   AST_ACK_RISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> $past(out_ack && a_all_valid && b_all_valid)); // R7

   AST_LATE_INPUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ack && !(a_all_valid && b_all_valid)) |=> !in_ack); // R7

   AST_ACK_FALL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ack) |-> $past(!out_ack && a_all_null && b_all_null)); // R8

   AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_done) |-> $past(q_all_valid)); // R9

   AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_done) |-> $past(q_all_null)); // R9

endmodule

// File: tb/sim_dr_eo_stage.sv
module sim_dr_eo_stage;

   localparam int LANES = 4;
   localparam int W = 2 * LANES;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_dr = '0;
   logic [W-1:0] b_dr = '0;
   logic         in_ack;
   logic [W-1:0] out_dr;
   logic         out_done;
   logic         mon_en = 1'b0;
   logic         mon_ack = 1'b0;
   logic         man_ack = 1'b0;
   logic         out_ack;

   int checks = 0;
   int fails = 0;
   int bad_codes = 0;
   logic [W-1:0] exp_q[$];

   assign out_ack = mon_en ? mon_ack : man_ack;

   always #2 clk = ~clk;   // 4 ns period

   dr_eo_stage #(.LANES(LANES), .EARLY_OUTPUT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .a_dr(a_dr), .b_dr(b_dr), .in_ack(in_ack),
      .out_dr(out_dr), .out_ack(out_ack), .out_done(out_done));

   // R1 encoding: false rail low bit, true rail high bit
   function automatic logic [W-1:0] enc(input logic [LANES-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < LANES; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
      return r;
   endfunction

   function automatic logic [W-1:0] zeros_only(input logic [LANES-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < LANES; i++) r[2*i +: 2] = v[i] ? 2'b00 : 2'b01;
      return r;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   // monitor: acts as downstream stage, pops expected words
   initial begin
      forever begin
         @(negedge clk);
         for (int i = 0; i < LANES; i++)
            if (out_dr[2*i +: 2] == 2'b11) bad_codes++;
         if (mon_en) begin
            if (!mon_ack && out_done) begin
               if (exp_q.size() == 0) begin
                  chk("R4 unexpected token", out_dr, '0);
               end else begin
                  chk("R3/R4 scoreboard word", out_dr, exp_q.pop_front());
               end
               mon_ack = 1'b1;
            end else if (mon_ack && !out_done) begin
               mon_ack = 1'b0;
            end
         end
      end
   end

   // driver: one token with per-operand arrival delays
   task automatic send(input logic [LANES-1:0] av, input logic [LANES-1:0] bv,
                       input int da, input int db);
      int maxd;
      maxd = (da > db) ? da : db;
      exp_q.push_back(enc(av & bv));
      for (int c = 0; c <= maxd; c++) begin
         if (c == da) a_dr = enc(av);
         if (c == db) b_dr = enc(bv);
         tick(1);
         if (c == da && db > da) begin
            chk("R3 early zero from a", out_dr, zeros_only(av));
            chk1("R7 late b holds in_ack", in_ack, 1'b0);
         end
         if (c == db && da > db) begin
            chk("R3 early zero from b", out_dr, zeros_only(bv));
            chk1("R7 late a holds in_ack", in_ack, 1'b0);
         end
      end
      while (!in_ack) tick(1);
      a_dr = '0;
      b_dr = '0;
      while (in_ack) tick(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      tick(3);
      chk("R10 rails NULL in reset", out_dr, '0);
      chk1("R10 in_ack low in reset", in_ack, 1'b0);
      chk1("R10 out_done low in reset", out_done, 1'b0);
      rst_n = 1'b1;
      tick(2);
      chk("R10 rails NULL after reset", out_dr, '0);

      // R6: data offered while downstream ack still high
      man_ack = 1'b1;
      a_dr = enc(4'b0000);
      b_dr = enc(4'b0000);
      tick(3);
      chk("R6 no data under ack", out_dr, '0);
      a_dr = '0;
      b_dr = '0;
      tick(1);
      man_ack = 1'b0;
      tick(2);
      chk1("R8 in_ack falls", in_ack, 1'b0);
      chk("R6 still NULL", out_dr, '0);

      // R3/R7/R5/R9/R8: early zero with b late
      a_dr = enc(4'b0000);
      tick(1);
      chk("R3 early zero all lanes", out_dr, 8'h55);
      tick(1);
      chk1("R9 out_done rises", out_done, 1'b1);
      tick(3);
      chk1("R7 in_ack waits for b", in_ack, 1'b0);
      b_dr = enc(4'b1111);
      tick(2);
      chk("R5 held after late b", out_dr, 8'h55);
      chk1("R7 in_ack waits for ack", in_ack, 1'b0);
      man_ack = 1'b1;
      tick(1);
      chk1("R7 in_ack rises", in_ack, 1'b1);
      chk("R5 held while inputs valid", out_dr, 8'h55);
      a_dr = '0;
      b_dr = '0;
      tick(1);
      chk("R5 return to NULL", out_dr, '0);
      tick(1);
      chk1("R9 out_done falls", out_done, 1'b0);
      man_ack = 1'b0;
      tick(1);
      chk1("R8 in_ack falls after ack low", in_ack, 1'b0);

      // R4: a single one does not decide
      a_dr = enc(4'b1111);
      tick(2);
      chk("R4 lone one stays NULL", out_dr, '0);
      b_dr = enc(4'b1111);
      tick(1);
      chk("R4 both ones", out_dr, 8'haa);
      man_ack = 1'b1;
      tick(1);
      chk1("R7 in_ack rises", in_ack, 1'b1);
      a_dr = '0;
      b_dr = '0;
      tick(1);
      chk("R5 NULL after ones", out_dr, '0);
      man_ack = 1'b0;
      tick(3);
      chk1("R8 in_ack low", in_ack, 1'b0);

      // scoreboard phase: back-to-back tokens with random skew
      mon_en = 1'b1;
      for (int t = 0; t < 40; t++) begin
         send(LANES'($urandom), LANES'($urandom),
              $urandom_range(0, 5), $urandom_range(0, 5));
      end
      while (exp_q.size() != 0 || out_done) tick(1);
      tick(4);
      chk1("R2 no 11 code seen", bad_codes == 0, 1'b1);
      chk1("R7/R8 handshake idle", in_ack, 1'b0);
      summary();
      $finish;
   end

endmodule